// File: doc/BRIEF.md
# Conversion Result FIFO with Discard

This block buffers 16-bit converter results between the moment each conversion completes and the moment the host or a DMA engine reads them. Each result arrives with a write strobe and a discard tag copied from that conversion's setup entry. A tagged result belongs to a conversion that was only run to keep the scan timing even, so it is dropped at the write side and takes no storage.

Software or a DMA engine drains the buffer through a read strobe. The read data is registered and appears in the cycle after the strobe. Three registered occupancy flags (not-empty, half-full, full) drive interrupt and DMA request logic. A result that arrives while the buffer is full is lost. It raises a sticky overflow error, which stays set until the error-clear input is pulsed.

The depth is a power-of-two parameter. The default is 512 words, and 2,048 words is the larger build option. The storage array is written so that a block RAM can be inferred.

Top module: `cvt_result_fifo`

## Requirements
- R1: A synchronous active-high reset empties the buffer. While reset is held and in the cycle after it is released, not_empty, half_full, full and ovf_err are all 0 and rd_data is 0.
- R2: Results that are written with wr_ghost=0 are read back in arrival order. After a read strobe on a non-empty buffer, rd_data shows the oldest word from the following cycle on.
- R3: A write with wr_ghost=1 stores nothing and changes no flag. The next read returns the next untagged result.
- R4: not_empty becomes 1 in the cycle after the clock edge that accepts the first untagged write into an empty buffer.
- R5: half_full is 1 exactly when occupancy is at least DEPTH/2.
- R6: full is 1 exactly when occupancy equals DEPTH.
- R7: An untagged write while full, without a read in the same cycle, is lost. The stored contents are not changed, and ovf_err reads 1 from the next cycle on.
- R8: ovf_err stays 1 until a cycle with ovf_clr=1. If a new overflow happens in the same cycle as ovf_clr, ovf_err stays 1.
- R9: A read and an untagged write in the same cycle while full are both accepted. full stays 1 and no overflow is raised.
- R10: A read strobe on an empty buffer is ignored: rd_data holds its value and the flags do not change.
- R11: A tagged write while full raises no overflow.
- R12: Depth is 2^DEPTH_LOG2 words. The default DEPTH_LOG2=9 gives 512 words, and DEPTH_LOG2=11 gives 2,048 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | A conversion completed; its result is on wr_data |
| wr_data | input | DATA_W | Converter result |
| wr_ghost | input | 1 | Discard tag: 1 drops this result |
| rd_stb | input | 1 | Host read strobe |
| rd_data | output | DATA_W | Registered read data, valid the cycle after rd_stb |
| not_empty | output | 1 | At least one word is stored |
| half_full | output | 1 | Occupancy is at least DEPTH/2 |
| full | output | 1 | Occupancy equals DEPTH |
| ovf_err | output | 1 | Sticky overflow error |
| ovf_clr | input | 1 | Clears ovf_err |

## Verification
An occupancy counter that drifts from the true pointer distance shows on the flags in the very next cycle. It also shows later as stale or repeated words on rd_data once the buffer drains. A pointer that moves on a tagged or rejected write shows as a skipped or duplicated word at the next read. A wrong overflow decision shows on ovf_err one cycle after the offending write, or as a missing word when the buffer is drained. The bench sweeps a depth-8 build through fill, overflow, pass-through-at-full, drain and a long mixed pattern, and compares every cycle against an arithmetic queue model.

// File: rtl/cvtq_pkg.sv
package cvtq_pkg;
  typedef struct packed {
    logic not_empty;
    logic half_full;
    logic full;
  } cvtq_flags_t;
endpackage

// File: rtl/cvtq_admit.sv
module cvtq_admit (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic wr_ghost,
  input  logic rd_stb,
  input  logic full,
  input  logic ovf_clr,
  output logic wr_ok,
  output logic ovf_err
);
  logic live_wr;
  logic ovf_hit;

  assign live_wr = wr_stb & ~wr_ghost;
  // a same-cycle read frees the slot the write needs
  assign wr_ok   = live_wr & (~full | rd_stb);
  assign ovf_hit = live_wr & full & ~rd_stb;

  always_ff @(posedge clk) begin
    if (rst)          ovf_err <= 1'b0;
    else if (ovf_hit) ovf_err <= 1'b1;
    else if (ovf_clr) ovf_err <= 1'b0;
  end

  assert_ovf_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_ghost && full && !rd_stb) |=> ovf_err);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf_err && !ovf_clr) |=> ovf_err);
  assert_ghost_full_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!ovf_err && wr_stb && wr_ghost) |=> !ovf_err);
endmodule

// File: rtl/cvtq_ptrs.sv
module cvtq_ptrs
  import cvtq_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ok,
  input  logic          rd_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output cvtq_flags_t   flags
);
  localparam int        DEPTH    = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

  logic [AW:0] count, count_nxt;

  always_comb begin
    unique case ({wr_ok, rd_ok})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      rd_addr <= '0;
      count   <= '0;
      flags   <= '0;
    end else begin
      if (wr_ok) wr_addr <= wr_addr + 1'b1;
      if (rd_ok) rd_addr <= rd_addr + 1'b1;
      count           <= count_nxt;
      flags.not_empty <= (count_nxt != '0);
      flags.half_full <= (count_nxt >= HALF_CNT);
      flags.full      <= (count_nxt == FULL_CNT);
    end
  end

  assert_flag_order_R5: assert property (@(posedge clk) disable iff (rst)
    flags.full |-> (flags.half_full && flags.not_empty));
  assert_ne_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (!flags.not_empty && wr_ok) |=> flags.not_empty);
  assert_full_no_grow_R6: assert property (@(posedge clk) disable iff (rst)
    (flags.full && wr_ok) |-> rd_ok);
endmodule

// File: rtl/cvtq_store.sv
module cvtq_store #(
  parameter int AW     = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: when full, the read slot is also the write slot
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cvt_result_fifo.sv
module cvt_result_fifo
  import cvtq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DEPTH_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ghost,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              not_empty,
  output logic              half_full,
  output logic              full,
  output logic              ovf_err,
  input  logic              ovf_clr
);
  cvtq_flags_t           flags;
  logic                  wr_ok, rd_ok;
  logic [DEPTH_LOG2-1:0] wr_addr, rd_addr;

  assign rd_ok     = rd_stb & flags.not_empty;
  assign not_empty = flags.not_empty;
  assign half_full = flags.half_full;
  assign full      = flags.full;

  cvtq_admit u_admit (
    .clk, .rst, .wr_stb, .wr_ghost, .rd_stb,
    .full(flags.full), .ovf_clr, .wr_ok, .ovf_err
  );

  cvtq_ptrs #(.AW(DEPTH_LOG2)) u_ptrs (
    .clk, .rst, .wr_ok, .rd_ok, .wr_addr, .rd_addr, .flags
  );

  cvtq_store #(.AW(DEPTH_LOG2), .DATA_W(DATA_W)) u_store (
    .clk, .rst, .we(wr_ok), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_addr), .rdata(rd_data)
  );

  assert_ghost_no_change_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_ghost && !rd_stb) |=> $stable({not_empty, half_full, full}));
  assert_empty_read_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !not_empty) |=> $stable(rd_data));
  assert_pass_at_full_R9: assert property (@(posedge clk) disable iff (rst)
    (full && wr_stb && !wr_ghost && rd_stb && !ovf_err && !ovf_clr)
      |=> (full && !ovf_err));
endmodule

// File: tb/tb_cvt_result_fifo.sv
module tb_cvt_result_fifo;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0, wr_ghost = 1'b0, rd_stb = 1'b0, ovf_clr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic not_empty, half_full, full, ovf_err;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_rd = '0;
  logic          exp_ovf = 1'b0;

  always #10 clk = ~clk;

  cvt_result_fifo #(.DATA_W(DW), .DEPTH_LOG2(AW)) dut (
    .clk, .rst, .wr_stb, .wr_data, .wr_ghost, .rd_stb,
    .rd_data, .not_empty, .half_full, .full, .ovf_err, .ovf_clr
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "not_empty", 32'(not_empty), 32'(q.size() != 0));
    check(tag, "half_full", 32'(half_full), 32'(q.size() >= D/2));
    check(tag, "full",      32'(full),      32'(q.size() == D));
    check(tag, "ovf_err",   32'(ovf_err),   32'(exp_ovf));
    check(tag, "rd_data",   32'(rd_data),   32'(exp_rd));
  endtask

  task automatic step(input string tag, input logic w, input logic g,
                      input logic [DW-1:0] d, input logic r, input logic c);
    logic rd_acc, wr_acc, hit;
    @(negedge clk);
    wr_stb = w; wr_ghost = g; wr_data = d; rd_stb = r; ovf_clr = c;
    rd_acc = r && (q.size() != 0);
    wr_acc = w && !g && ((q.size() < D) || r);
    hit    = w && !g && (q.size() == D) && !r;
    @(posedge clk);
    if (rd_acc) exp_rd = q.pop_front();
    if (wr_acc) q.push_back(d);
    if (hit) exp_ovf = 1'b1;
    else if (c) exp_ovf = 1'b0;
    #5;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: state during and just after reset
    repeat (3) @(posedge clk);
    #5 check_all("R1");
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #5 check_all("R1");

    // R4: first untagged write raises not_empty on the next edge
    step("R4", 1, 0, 16'h1000, 0, 0);
    // R5 R6 R12: fill to depth, flags tracked at each occupancy
    for (int i = 1; i < D; i++) step("R5 R6 R12", 1, 0, 16'h1000 + DW'(i), 0, 0);
    // R7: lost writes while full
    step("R7", 1, 0, 16'hDEAD, 0, 0);
    step("R7", 1, 0, 16'hBEEF, 0, 0);
    // R8: sticky, then clear, then set wins over clear
    step("R8", 0, 0, 16'h0, 0, 0);
    step("R8", 0, 0, 16'h0, 0, 1);
    step("R8", 1, 0, 16'hBAD0, 0, 1);
    step("R8", 0, 0, 16'h0, 0, 1);
    // R11: tagged write while full is silent
    step("R11", 1, 1, 16'hBAD1, 0, 0);
    step("R11", 1, 1, 16'hBAD2, 0, 0);
    // R9: read plus write at full passes
    for (int i = 0; i < 3; i++) step("R9", 1, 0, 16'h2000 + DW'(i), 1, 0);
    // R2: drain in order
    for (int i = 0; i < D; i++) step("R2", 0, 0, 16'h0, 1, 0);
    // R10: reads on empty are ignored
    step("R10", 0, 0, 16'h0, 1, 0);
    step("R10", 0, 0, 16'h0, 1, 0);
    // R3: tagged writes interleaved with real ones
    step("R3", 1, 1, 16'h3333, 0, 0);
    step("R3", 1, 0, 16'h3001, 0, 0);
    step("R3", 1, 1, 16'h3334, 0, 0);
    step("R3", 1, 0, 16'h3002, 0, 0);
    step("R3", 1, 1, 16'h3335, 1, 0);
    step("R3", 0, 0, 16'h0, 1, 0);
    step("R3", 0, 0, 16'h0, 1, 0);
    // mixed sweep over every strobe combination
    for (int i = 0; i < 600; i++) begin
      logic w, g, r, c;
      w = ((i % 3) != 1) || ((i / 64) % 2 == 1);
      g = (i % 5) == 0;
      r = ((i * 7) % 4 == 0) || ((i / 64) % 3 == 2);
      c = (i % 37) == 0;
      step("R2 R3 R7 R9", w, g, DW'(16'h4000 + i * 13), r, c);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule